// File: doc/BRIEF.md
# Read-Protection Downgrade Sequencer

This block manages the only legal path from the read-locked protection level back to the open level. It watches option-area commands from the bus. A bus erase of the option area is recorded as the first step. A following bus write of the open-level code 0xA5 to the protection byte then starts a sequence the bus cannot interrupt. The sequence is a whole main-array erase, followed by the block's own program of 0xA5 into the protection byte. Both operations go to an external flash engine through a request/acknowledge/done handshake.

The protection level that the rest of the chip sees is latched from the stored option bytes only when a reload strobe arrives, which happens at system reset. The new open level therefore does not apply until the next reload. Erasing the option area alone leaves the stored byte at 0xFF, which still decodes as the read-locked level, so no array erase follows from it. In the permanent level every option command is refused.

Top module: `rdp_regress_seq`

## Requirements
- R1: After reset the sequencer status is IDLE (code 0), `eng_req`, `seq_busy` and `cmd_reject` are low, and `eff_level` reads read-locked (code 1).
- R2: On `sys_reload` the effective level is loaded from the stored bytes and the sequencer returns to IDLE. The level is permanent (code 2) when `stored_top` is set, open (code 0) when `stored_rdp` equals 0xA5, and read-locked (code 1) otherwise.
- R3: An option erase strobe moves IDLE to OPT_ERASED (code 1) only while the option area is unlocked and the level is read-locked. A strobe while locked is refused: `cmd_reject` pulses high for one cycle, one clock after the strobe, and the status does not change.
- R4: An option erase by itself never raises `eng_req`.
- R5: In OPT_ERASED, a bus write of 0xA5 moves the sequencer to MASS_ERASE (code 2). From the next cycle it holds `eng_req` high with `eng_op`=0 (array erase) until `eng_ack` is sampled high.
- R6: An `eng_done` after the erase acknowledge moves the sequencer to RDP_WRITE (code 3). There it requests `eng_op`=1 (option program) with `eng_data`=0xA5, holding the request until acknowledged. The next `eng_done` moves it to DONE (code 4).
- R7: `seq_busy` is high exactly in MASS_ERASE and RDP_WRITE. Any bus strobe during that time is rejected and leaves the status unchanged.
- R8: At the permanent level, option erase and write strobes are rejected and the sequencer stays in IDLE.
- R9: In OPT_ERASED, relocking the option area or writing any value other than 0xA5 returns the sequencer to IDLE without a request. A write seen in IDLE starts nothing.
- R10: `eff_level` changes only on `sys_reload`. Finishing the sequence leaves it at read-locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_unlocked | input | 1 | Option area unlocked by the key logic |
| bus_opt_erase | input | 1 | Bus option-area page erase strobe |
| bus_opt_wr | input | 1 | Bus write strobe to the protection byte |
| bus_opt_wdata | input | 8 | Bus write data |
| eng_req | output | 1 | Request to the flash engine |
| eng_op | output | 1 | 0 = main-array erase, 1 = option program |
| eng_data | output | 8 | Byte to program (0xA5) |
| eng_ack | input | 1 | Engine accepted the request |
| eng_done | input | 1 | Engine finished the operation |
| sys_reload | input | 1 | Option-byte reload strobe at system reset |
| stored_rdp | input | 8 | Stored protection byte |
| stored_top | input | 1 | Stored second byte pair decodes as permanent level |
| seq_busy | output | 1 | Internal erase/program in progress |
| cmd_reject | output | 1 | One-cycle pulse: bus command refused |
| seq_state | output | 3 | Sequencer status code |
| eff_level | output | 2 | Effective protection level |

## Verification
The properties assume the flash engine drives `eng_ack` and `eng_done` only while a request is pending or after it has been acknowledged. They also assume that `sys_reload` is the only event that may abort a pending request, so every hold property exempts a reload cycle. The stimulus follows this. The engine model acknowledges only while `eng_req` is high, signals done only after the acknowledge, and issues reloads only in IDLE or DONE. Bus strobes last one cycle each, as a bus command would.

// File: rtl/rdp_seq_pkg.sv
package rdp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_OPT_ERASED = 3'd1,
        ST_MASS_ERASE = 3'd2,
        ST_RDP_WRITE  = 3'd3,
        ST_DONE       = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        LVL_OPEN      = 2'd0,
        LVL_READ_LOCK = 2'd1,
        LVL_PERMANENT = 2'd2
    } prot_lvl_e;

    typedef struct packed {
        seq_state_e state;
        logic       pend;
        logic       reject;
    } seq_regs_t;

endpackage

// File: rtl/rdp_level_latch.sv
module rdp_level_latch
    import rdp_seq_pkg::*;
#(
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] UNPROT_VAL = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [DATA_W-1:0] stored_rdp,
    input  logic              stored_top,
    output prot_lvl_e         level
);
    prot_lvl_e lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (reload) begin
            if (stored_top)
                lvl_d = LVL_PERMANENT;
            else if (stored_rdp == UNPROT_VAL)
                lvl_d = LVL_OPEN;
            else
                lvl_d = LVL_READ_LOCK;
        end
    end

    // Safe default until the first reload: read-locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_READ_LOCK;
        else        lvl_q <= lvl_d;
    end

    assign level = lvl_q;
endmodule

// File: rtl/rdp_cmd_filter.sv
module rdp_cmd_filter
    import rdp_seq_pkg::*;
(
    input  logic       bus_erase,
    input  logic       bus_wr,
    input  logic       unlocked,
    input  prot_lvl_e  level,
    input  seq_state_e state,
    output logic       erase_ok,
    output logic       wr_ok,
    output logic       refuse,
    output logic       busy
);
    logic any_cmd;
    logic allowed_lvl;

    always_comb begin
        busy        = (state == ST_MASS_ERASE) || (state == ST_RDP_WRITE);
        any_cmd     = bus_erase || bus_wr;
        allowed_lvl = (level == LVL_READ_LOCK);
        refuse      = any_cmd && (busy || !unlocked || (level == LVL_PERMANENT));
        erase_ok    = bus_erase && unlocked && allowed_lvl
                      && ((state == ST_IDLE) || (state == ST_OPT_ERASED));
        wr_ok       = bus_wr && unlocked && allowed_lvl && (state == ST_OPT_ERASED);
    end
endmodule

// File: rtl/rdp_regress_seq.sv
module rdp_regress_seq
    import rdp_seq_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] UNPROT_VAL = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_unlocked,
    input  logic              bus_opt_erase,
    input  logic              bus_opt_wr,
    input  logic [DATA_W-1:0] bus_opt_wdata,
    output logic              eng_req,
    output logic              eng_op,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_ack,
    input  logic              eng_done,
    input  logic              sys_reload,
    input  logic [DATA_W-1:0] stored_rdp,
    input  logic              stored_top,
    output logic              seq_busy,
    output logic              cmd_reject,
    output logic [2:0]        seq_state,
    output logic [1:0]        eff_level
);
    localparam seq_regs_t RESET_REGS = '{state: ST_IDLE, pend: 1'b0, reject: 1'b0};

    seq_regs_t r_d, r_q;
    prot_lvl_e level;
    logic      erase_ok, wr_ok, refuse, busy;

    rdp_level_latch #(.DATA_W(DATA_W), .UNPROT_VAL(UNPROT_VAL)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (sys_reload),
        .stored_rdp (stored_rdp),
        .stored_top (stored_top),
        .level      (level)
    );

    rdp_cmd_filter u_filter (
        .bus_erase (bus_opt_erase),
        .bus_wr    (bus_opt_wr),
        .unlocked  (opt_unlocked),
        .level     (level),
        .state     (r_q.state),
        .erase_ok  (erase_ok),
        .wr_ok     (wr_ok),
        .refuse    (refuse),
        .busy      (busy)
    );

    always_comb begin
        r_d        = r_q;
        r_d.reject = refuse;
        if (sys_reload) begin
            r_d.state = ST_IDLE;
            r_d.pend  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (erase_ok) r_d.state = ST_OPT_ERASED;
                end
                ST_OPT_ERASED: begin
                    if (!opt_unlocked) begin
                        r_d.state = ST_IDLE;
                    end else if (wr_ok) begin
                        if (bus_opt_wdata == UNPROT_VAL) begin
                            r_d.state = ST_MASS_ERASE;
                            r_d.pend  = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_MASS_ERASE, ST_RDP_WRITE: begin
                    if (r_q.pend) begin
                        if (eng_ack) r_d.pend = 1'b0;
                    end else if (eng_done) begin
                        if (r_q.state == ST_MASS_ERASE) begin
                            r_d.state = ST_RDP_WRITE;
                            r_d.pend  = 1'b1;
                        end else begin
                            r_d.state = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    r_d.state = ST_DONE;
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.pend  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign eng_req    = r_q.pend && busy;
    assign eng_op     = (r_q.state == ST_RDP_WRITE);
    assign eng_data   = UNPROT_VAL;
    assign seq_busy   = busy;
    assign cmd_reject = r_q.reject;
    assign seq_state  = r_q.state;
    assign eff_level  = level;
endmodule

// File: rtl/rdp_regress_seq_chk.sv
module rdp_regress_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_reload,
    input logic       eng_req,
    input logic       eng_ack,
    input logic       eng_op,
    input logic       seq_busy,
    input logic [2:0] seq_state,
    input logic [1:0] eff_level
);
    // R4: a request only ever comes out of the busy phases
    a_r4_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> seq_busy);

    // R5: an unacknowledged request stays up
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && !sys_reload) |=> eng_req);

    // R6: the requested operation does not change under a pending request
    a_r6_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && !sys_reload) |=> $stable(eng_op));

    // R5: busy is entered only from the option-erased step
    a_r5_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> ($past(seq_state) == 3'd1));

    // R8: permanent level keeps the sequencer idle
    a_r8_top_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_level == 2'd2) |-> (seq_state == 3'd0));

    // R10: level moves only with a reload
    a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_reload |=> $stable(eff_level));
endmodule

bind rdp_regress_seq rdp_regress_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_reload (sys_reload),
    .eng_req    (eng_req),
    .eng_ack    (eng_ack),
    .eng_op     (eng_op),
    .seq_busy   (seq_busy),
    .seq_state  (seq_state),
    .eff_level  (eff_level)
);

// File: tb/rdp_regress_seq_test.sv
`timescale 1ns/1ps
module rdp_regress_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_unlocked = 1'b0;
    logic       bus_opt_erase = 1'b0;
    logic       bus_opt_wr = 1'b0;
    logic [7:0] bus_opt_wdata = 8'h00;
    logic       eng_req, eng_op;
    logic [7:0] eng_data;
    logic       eng_ack = 1'b0;
    logic       eng_done = 1'b0;
    logic       sys_reload = 1'b0;
    logic [7:0] stored_rdp = 8'hFF;
    logic       stored_top = 1'b0;
    logic       seq_busy, cmd_reject;
    logic [2:0] seq_state;
    logic [1:0] eff_level;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rdp_regress_seq uut (
        .clk(clk), .rst_n(rst_n), .opt_unlocked(opt_unlocked),
        .bus_opt_erase(bus_opt_erase), .bus_opt_wr(bus_opt_wr),
        .bus_opt_wdata(bus_opt_wdata), .eng_req(eng_req), .eng_op(eng_op),
        .eng_data(eng_data), .eng_ack(eng_ack), .eng_done(eng_done),
        .sys_reload(sys_reload), .stored_rdp(stored_rdp), .stored_top(stored_top),
        .seq_busy(seq_busy), .cmd_reject(cmd_reject), .seq_state(seq_state),
        .eff_level(eff_level)
    );

    // {stored_rdp, stored_top, expected level}
    localparam logic [10:0] LVL_VEC [6] = '{
        {8'hFF, 1'b0, 2'd1},
        {8'hA5, 1'b0, 2'd0},
        {8'hA5, 1'b1, 2'd2},
        {8'h00, 1'b0, 2'd1},
        {8'hA4, 1'b0, 2'd1},
        {8'h33, 1'b1, 2'd2}
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reload(input logic [7:0] rdp, input logic top);
        stored_rdp = rdp;
        stored_top = top;
        sys_reload = 1'b1;
        cyc();
        sys_reload = 1'b0;
    endtask

    task automatic strobe_erase();
        bus_opt_erase = 1'b1;
        cyc();
        bus_opt_erase = 1'b0;
    endtask

    task automatic strobe_wr(input logic [7:0] d);
        bus_opt_wr = 1'b1;
        bus_opt_wdata = d;
        cyc();
        bus_opt_wr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", seq_state, 0);
        check("R1 req", eng_req, 0);
        check("R1 busy", seq_busy, 0);
        check("R1 reject", cmd_reject, 0);
        check("R1 level", eff_level, 1);
        rst_n = 1'b1;
        cyc();

        // R2 level decode table
        foreach (LVL_VEC[i]) begin
            reload(LVL_VEC[i][10:3], LVL_VEC[i][2]);
            check("R2 level", eff_level, LVL_VEC[i][1:0]);
            check("R2 state", seq_state, 0);
        end
        reload(8'hFF, 1'b0);

        // R3 locked erase refused
        strobe_erase();
        check("R3 reject pulse", cmd_reject, 1);
        check("R3 locked state", seq_state, 0);
        cyc();
        check("R3 reject one cycle", cmd_reject, 0);

        // R9 write in idle starts nothing
        opt_unlocked = 1'b1;
        strobe_wr(8'hA5);
        check("R9 idle write", seq_state, 0);

        // R3/R4 accepted erase, no request
        strobe_erase();
        check("R3 erased", seq_state, 1);
        check("R3 no reject", cmd_reject, 0);
        check("R4 no req", eng_req, 0);
        cyc();
        cyc();
        check("R4 still no req", eng_req, 0);

        // R9 wrong value
        strobe_wr(8'h5A);
        check("R9 bad value", seq_state, 0);
        check("R9 bad value req", eng_req, 0);

        // R9 relock
        strobe_erase();
        opt_unlocked = 1'b0;
        cyc();
        check("R9 relock", seq_state, 0);
        opt_unlocked = 1'b1;

        // R5 full sequence
        strobe_erase();
        strobe_wr(8'hA5);
        check("R5 state", seq_state, 2);
        check("R5 req", eng_req, 1);
        check("R5 op", eng_op, 0);
        check("R7 busy", seq_busy, 1);
        cyc();
        cyc();
        check("R5 req held", eng_req, 1);
        strobe_erase();
        check("R7 reject busy", cmd_reject, 1);
        check("R7 state kept", seq_state, 2);
        eng_ack = 1'b1;
        cyc();
        eng_ack = 1'b0;
        check("R5 req drop", eng_req, 0);
        check("R7 busy waiting", seq_busy, 1);
        eng_done = 1'b1;
        cyc();
        eng_done = 1'b0;
        // R6 option program
        check("R6 state", seq_state, 3);
        check("R6 req", eng_req, 1);
        check("R6 op", eng_op, 1);
        check("R6 data", eng_data, 8'hA5);
        strobe_wr(8'hA5);
        check("R7 write rejected", cmd_reject, 1);
        check("R7 state kept 3", seq_state, 3);
        eng_ack = 1'b1;
        cyc();
        eng_ack = 1'b0;
        check("R6 req drop", eng_req, 0);
        eng_done = 1'b1;
        cyc();
        eng_done = 1'b0;
        check("R6 done", seq_state, 4);
        check("R7 busy clear", seq_busy, 0);
        check("R10 level unchanged", eff_level, 1);

        // R2 reload after completion
        reload(8'hA5, 1'b0);
        check("R2 open level", eff_level, 0);
        check("R2 back idle", seq_state, 0);

        // R8 permanent level
        reload(8'hA5, 1'b1);
        check("R8 level", eff_level, 2);
        strobe_erase();
        check("R8 reject", cmd_reject, 1);
        check("R8 idle", seq_state, 0);
        strobe_wr(8'hA5);
        check("R8 write reject", cmd_reject, 1);
        check("R8 no req", eng_req, 0);

        finished = 1'b1;
        summary();
    end
endmodule